// File: doc/BRIEF.md
# Inter-Processor Mailbox Interrupt Controller

This block lets any processor in a small cluster interrupt another one and hand it a 16-bit message. Each processor owns two 32-bit registers on a simple register bus, a command word and a mailbox word. The block drives one level-sensitive interrupt line per processor.

A processor sends a message by writing its own command word with the send flag set. That write names the destination index and carries the payload. The mailbox of the destination is then overwritten with a pending flag, the sender's index and the payload, and the destination's interrupt line goes high. The receiver reads its mailbox and then writes its own command word with the clear flag set. This drops its pending flag and its interrupt line. A single write may both send and clear, and the send is applied first.

Top module: `ipi_mailbox`

## Requirements
- R1: Under synchronous active-high reset every command word and mailbox word reads as zero and every interrupt output is low.
- R2: The command word of processor n sits at byte address 8n and the mailbox word at 8n+4 (address bit 2 picks the mailbox, bits from 3 up pick the processor, bits 1:0 are ignored). Any write to a command word stores the whole 32-bit value, and the same value reads back.
- R3: A command write with bit 30 (send) set and destination field bits 29:16 below the processor count overwrites the destination mailbox. The new mailbox holds bit 31 = 0, bit 30 (pending) = 1, the writer's index in bits 29:16 and the written bits 15:0 in bits 15:0.
- R4: Each interrupt output equals the pending bit of that processor's mailbox. It rises on the clock edge that takes the send write.
- R5: A new message replaces an earlier unacknowledged one completely.
- R6: A command write with bit 31 (clear) set clears only the pending bit of the writer's own mailbox and lowers the writer's interrupt. Sender index and payload are kept.
- R7: When a processor sends to itself with both bits 31 and 30 set, the send is applied first and then the clear. It ends with pending at 0 and its interrupt low, while the sender and payload fields hold the new values.
- R8: A write with both flags aimed at another processor both loads the destination mailbox and clears the writer's pending bit in the same cycle.
- R9: Writes to a mailbox word change no register and no interrupt.
- R10: A send whose destination index is at or above the processor count is dropped. No mailbox and no interrupt changes, but the command word is still stored.
- R11: For a processor index at or above the processor count, both registers read as zero and writes to them change nothing.
- R12: Read data follows the address in the same cycle. A write becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_o | output | NUM_CPUS | Level interrupt, one per processor |

## Verification
The bench aims at ordering and aliasing corners. A self-send with both flags shows whether the clear follows the send; a design that ran them the other way would leave the interrupt stuck high. A second message to a busy mailbox must replace it completely, and a clear must keep the sender and payload; a design that zeroed the whole word would lose the message. The bench is built with three processors, so a destination index of 3 and the fourth register slot are both out of range. A design that wrapped the index would corrupt processor 0, and one that accepted mailbox writes would change pending state, both of which show up at the read port and the interrupt lines.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;

   localparam int WORD_W    = 32;
   localparam int IDX_FLD_W = 14;
   localparam int MSG_W     = 16;

   typedef struct packed {
      logic                 clear;
      logic                 send;
      logic [IDX_FLD_W-1:0] dest;
      logic [MSG_W-1:0]     msg;
   } cmd_word_t;

   typedef struct packed {
      logic                 zero;
      logic                 pend;
      logic [IDX_FLD_W-1:0] sender;
      logic [MSG_W-1:0]     msg;
   } mbox_word_t;

endpackage

// File: rtl/ipi_win_decode.sv
module ipi_win_decode #(
   parameter int ADDR_W   = 5,
   parameter int NUM_CPUS = 4,
   localparam int IDX_W   = ADDR_W - 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic              sel_mbox,
   output logic              in_range
);

   logic unused_byte_lane;
   assign unused_byte_lane = ^addr[1:0];

   assign idx      = addr[ADDR_W-1:3];
   assign sel_mbox = addr[2];

   generate
      if (NUM_CPUS == (1 << IDX_W)) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_partial
         assign in_range = (int'(idx) < NUM_CPUS);
      end
   endgenerate

endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
   import ipi_mbox_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_cmd,
   input  logic                 send_hit,
   input  logic                 clear_hit,
   input  logic [IDX_FLD_W-1:0] send_src,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    cmd_o,
   output logic [WORD_W-1:0]    mbox_o,
   output logic                 irq_o
);

   logic [WORD_W-1:0] cmd_q;
   mbox_word_t        mbox_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q  <= '0;
         mbox_q <= '0;
      end else begin
         if (wr_cmd) begin
            cmd_q <= wdata;
         end
         if (send_hit) begin
            mbox_q.zero   <= 1'b0;
            mbox_q.pend   <= 1'b1;
            mbox_q.sender <= send_src;
            mbox_q.msg    <= wdata[MSG_W-1:0];
         end
         if (clear_hit) begin
            mbox_q.pend <= 1'b0;
         end
      end
   end

   assign cmd_o  = cmd_q;
   assign mbox_o = mbox_q;
   assign irq_o  = mbox_q.pend;

   assert_cmd_store_R2: assert property (@(posedge clk) disable iff (rst)
      wr_cmd |=> (cmd_o == $past(wdata)));

   assert_send_load_R3: assert property (@(posedge clk) disable iff (rst)
      (send_hit && !clear_hit) |=> (mbox_o[MSG_W-1:0] == $past(wdata[MSG_W-1:0])));

   assert_send_raise_R4: assert property (@(posedge clk) disable iff (rst)
      (send_hit && !clear_hit) |=> irq_o);

   assert_clear_lower_R6: assert property (@(posedge clk) disable iff (rst)
      clear_hit |=> !irq_o);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!wr_cmd && !send_hit && !clear_hit) |=> ($stable(mbox_o) && $stable(cmd_o)));

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
   import ipi_mbox_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int ADDR_W   = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_CPUS-1:0] irq_o
);

   localparam int IDX_W = ADDR_W - 3;
   localparam logic [IDX_FLD_W-1:0] CPU_LIM = IDX_FLD_W'(NUM_CPUS);

   initial begin
      assert (NUM_CPUS >= 1 && NUM_CPUS <= 4)
         else $error("NUM_CPUS must be 1..4");
      assert (ADDR_W >= 3 && (1 << (ADDR_W - 3)) >= NUM_CPUS)
         else $error("ADDR_W too narrow for NUM_CPUS");
   end

   logic [IDX_W-1:0] idx;
   logic             sel_mbox;
   logic             in_range;

   ipi_win_decode #(.ADDR_W(ADDR_W), .NUM_CPUS(NUM_CPUS)) u_dec (
      .addr     (bus_addr),
      .idx      (idx),
      .sel_mbox (sel_mbox),
      .in_range (in_range)
   );

   cmd_word_t cmd_in;
   logic      cmd_wr;
   logic      send_ok;
   logic      clear_ok;

   assign cmd_in   = cmd_word_t'(bus_wdata);
   assign cmd_wr   = bus_we && !sel_mbox && in_range;
   assign send_ok  = cmd_wr && cmd_in.send && (cmd_in.dest < CPU_LIM);
   assign clear_ok = cmd_wr && cmd_in.clear;

   logic [31:0] cmd_arr  [NUM_CPUS];
   logic [31:0] mbox_arr [NUM_CPUS];
   logic [NUM_CPUS*32-1:0] mbox_flat;
   logic [NUM_CPUS*32-1:0] cmd_flat;

   genvar g;
   generate
      for (g = 0; g < NUM_CPUS; g++) begin : g_slot
         logic is_me;
         assign is_me = (idx == IDX_W'(g));

         ipi_cpu_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_cmd    (cmd_wr && is_me),
            .send_hit  (send_ok && (cmd_in.dest == IDX_FLD_W'(g))),
            .clear_hit (clear_ok && is_me),
            .send_src  (IDX_FLD_W'(idx)),
            .wdata     (bus_wdata),
            .cmd_o     (cmd_arr[g]),
            .mbox_o    (mbox_arr[g]),
            .irq_o     (irq_o[g])
         );

         assign mbox_flat[g*32 +: 32] = mbox_arr[g];
         assign cmd_flat[g*32 +: 32]  = cmd_arr[g];
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CPUS; i++) begin
         if (in_range && (idx == IDX_W'(i))) begin
            bus_rdata = sel_mbox ? mbox_arr[i] : cmd_arr[i];
         end
      end
   end

   assert_mbox_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
      (bus_we && sel_mbox) |=> ($stable(mbox_flat) && $stable(cmd_flat) && $stable(irq_o)));

   assert_far_dest_dropped_R10: assert property (@(posedge clk) disable iff (rst)
      (cmd_wr && cmd_in.send && !cmd_in.clear && (cmd_in.dest >= CPU_LIM))
      |=> ($stable(mbox_flat) && $stable(irq_o)));

   assert_oob_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
      (bus_we && !in_range) |=> ($stable(mbox_flat) && $stable(cmd_flat) && $stable(irq_o)));

   assert_oob_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
      !in_range |-> (bus_rdata == 32'h0));

   assert_irq_single_step_R4: assert property (@(posedge clk) disable iff (rst)
      !bus_we |=> $stable(irq_o));

endmodule

// File: tb/ipi_mailbox_tb.sv
`timescale 1ns/1ps
module ipi_mailbox_tb;

   localparam int NCPU = 3;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [4:0]      bus_addr = '0;
   logic            bus_we = 1'b0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCPU-1:0] irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ipi_mailbox #(.NUM_CPUS(NCPU), .ADDR_W(5)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic irq_chk(input string req, input logic [NCPU-1:0] exp);
      #1;
      chk(req, 32'(irq_o), 32'(exp));
   endtask

   task automatic t_reset();
      for (int c = 0; c < 4; c++) begin
         rd_chk("R1 cmd", 5'(c*8), 32'h0);
         rd_chk("R1 mbox", 5'(c*8+4), 32'h0);
      end
      irq_chk("R1 irq", '0);
   endtask

   task automatic t_timing();
      @(negedge clk);
      bus_addr  = 5'd16;
      bus_wdata = 32'h0000_00A5;
      bus_we    = 1'b1;
      #1;
      chk("R12 before edge", bus_rdata, 32'h0);
      @(posedge clk);
      #1;
      chk("R12 after edge", bus_rdata, 32'h0000_00A5);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic t_readback();
      wr(5'd8, 32'h0000_1234);
      rd_chk("R2 cmd1", 5'd8, 32'h0000_1234);
      wr(5'd9, 32'h0000_5678);
      rd_chk("R2 low bits ignored", 5'd11, 32'h0000_5678);
      rd_chk("R2 mbox1 untouched", 5'd12, 32'h0);
      irq_chk("R2 irq", 3'b000);
   endtask

   task automatic t_send();
      wr(5'd0, 32'h4002_BEEF);
      rd_chk("R3 mbox2", 5'd20, 32'h4000_BEEF);
      irq_chk("R4 irq after send", 3'b100);
      wr(5'd8, 32'h4000_0055);
      rd_chk("R3 mbox0", 5'd4, 32'h4001_0055);
      irq_chk("R4 irq second send", 3'b101);
   endtask

   task automatic t_overwrite();
      wr(5'd8, 32'h4002_0777);
      rd_chk("R5 mbox2 replaced", 5'd20, 32'h4001_0777);
      irq_chk("R5 irq", 3'b101);
   endtask

   task automatic t_clear();
      wr(5'd16, 32'h8000_0000);
      rd_chk("R6 mbox2 fields kept", 5'd20, 32'h0001_0777);
      irq_chk("R6 irq2 low", 3'b001);
      rd_chk("R6 cmd2 stored", 5'd16, 32'h8000_0000);
   endtask

   task automatic t_both();
      wr(5'd0, 32'hC001_00AA);
      rd_chk("R8 writer cleared", 5'd4, 32'h0001_0055);
      rd_chk("R8 dest loaded", 5'd12, 32'h4000_00AA);
      irq_chk("R8 irq", 3'b010);
   endtask

   task automatic t_self();
      wr(5'd8, 32'hC001_0033);
      rd_chk("R7 self mbox", 5'd12, 32'h0001_0033);
      irq_chk("R7 irq", 3'b000);
   endtask

   task automatic t_mbox_write();
      wr(5'd16, 32'h4001_0044);
      rd_chk("R3 mbox1", 5'd12, 32'h4002_0044);
      wr(5'd12, 32'hFFFF_FFFF);
      rd_chk("R9 mbox1 kept", 5'd12, 32'h4002_0044);
      wr(5'd12, 32'h0000_0000);
      rd_chk("R9 mbox1 kept zero", 5'd12, 32'h4002_0044);
      rd_chk("R9 cmd1 kept", 5'd8, 32'hC001_0033);
      irq_chk("R9 irq", 3'b010);
   endtask

   task automatic t_far_dest();
      wr(5'd0, 32'h4003_1111);
      rd_chk("R10 cmd0 stored", 5'd0, 32'h4003_1111);
      wr(5'd0, 32'h7FFF_2222);
      rd_chk("R10 mbox0", 5'd4, 32'h0001_0055);
      rd_chk("R10 mbox1", 5'd12, 32'h4002_0044);
      rd_chk("R10 mbox2", 5'd20, 32'h0001_0777);
      irq_chk("R10 irq", 3'b010);
   endtask

   task automatic t_oob();
      wr(5'd24, 32'hC000_2222);
      wr(5'd28, 32'hFFFF_FFFF);
      rd_chk("R11 cmd3 zero", 5'd24, 32'h0);
      rd_chk("R11 mbox3 zero", 5'd28, 32'h0);
      rd_chk("R11 mbox0 kept", 5'd4, 32'h0001_0055);
      irq_chk("R11 irq", 3'b010);
   endtask

   task automatic t_rereset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd_chk("R1 cmd0 after reset", 5'd0, 32'h0);
      rd_chk("R1 mbox1 after reset", 5'd12, 32'h0);
      irq_chk("R1 irq after reset", 3'b000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_timing();
      t_readback();
      t_send();
      t_overwrite();
      t_clear();
      t_both();
      t_self();
      t_mbox_write();
      t_far_dest();
      t_oob();
      t_rereset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule